// File: doc/BRIEF.md
# GPIO Bank with Interrupt Detection

The block is a bank of up to 32 general-purpose lines behind a plain 32-bit register bus. Each line can be a plain input, a driven output, or an interrupt source. The bus uses a single write strobe. Reads are combinational from the byte address. The bus has no wait states.

Every pin input passes through a two-flop synchroniser. A third flop holds the previous sample so that edges can be found. An interrupt line can sense a level or an edge. A polarity bit picks high/rising or low/falling. A both-edge bit makes any transition count.

Edge events latch into a sticky status bit, which software clears by writing ones. Level lines report their current level directly. A per-line enable mask is set through one register and cleared through another. A single interrupt output is raised whenever an enabled line has status.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads 0, `pin_oe` is 0 and `irq` is 0, so every line starts as an input with its interrupt disabled.
- R2: A line drives its pad only in general mode (mode bit at 0x00 is 0) with its direction bit at 0x04 set to 1. Then `pin_oe` is 1 and `pin_out` equals its output-data bit at 0x08. Otherwise both are 0. Register 0x08 reads back as written.
- R3: Reading 0x0C returns the pin levels after the two-flop synchroniser. A change on `pin_in` before a clock edge becomes visible after the second rising edge.
- R4: For an interrupt line (0x00 bit = 1) in edge mode (0x24 bit = 1) with the both-edge bit at 0x4C clear, polarity 0 at 0x20 latches status on a rising pin edge and polarity 1 on a falling one. The opposite transition sets nothing. Status is visible at 0x10 after the third rising clock edge following the pin change.
- R5: For an edge-mode interrupt line whose both-edge bit is 1, either transition latches status, whatever the polarity bit.
- R6: For an interrupt line in level mode (0x24 bit = 0), the status bit equals the synchronised pin XOR the polarity bit. It does not latch, and the both-edge bit has no effect.
- R7: A line in general mode never sets its status bit.
- R8: Writing 1 to a bit at 0x14 clears that latched status bit, and writing 0 leaves it unchanged. If an edge arrives in the same cycle as the clear, the status stays set.
- R9: Writing 1 to a bit at 0x1C enables that line. A bit written 0 there is unchanged. Writing 0 to a bit at 0x18 disables the line, and a bit written 1 there is unchanged. Reading 0x18 returns the enable bits.
- R10: `irq` is 1 exactly when some line has both status and enable set.
- R11: Register 0x28 is plain read/write storage with no effect on sensing. Unmapped addresses, 0x14 and 0x1C read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 7 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| pin_in | input | NLINES | Pad input levels |
| pin_out | output | NLINES | Pad output data |
| pin_oe | output | NLINES | Pad output enable |
| irq | output | 1 | Combined interrupt |

## Verification
A vector table drives the sensing logic through each mode. Rising-only and falling-only cases cover both polarities. Reversed transitions show that the unselected edge is ignored. A mixed pattern under both-edge mode shows that polarity is overridden. Level-high and level-low cases confirm that status follows the pin. Patterns on lines in general mode confirm that they stay silent. A split configuration with half the lines in interrupt mode separates the per-line mode bit from the global behaviour. Directed cases then cover synchroniser latency, partial write-one-to-clear, a set and a clear in the same cycle, and the asymmetric enable writes.

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int NLINES = 32,
  parameter int AW     = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NLINES-1:0] pin_in,
  output logic [NLINES-1:0] pin_out,
  output logic [NLINES-1:0] pin_oe,
  output logic              irq
);
  localparam logic [AW-1:0] A_MODE   = AW'('h00);
  localparam logic [AW-1:0] A_DIR    = AW'('h04);
  localparam logic [AW-1:0] A_DOUT   = AW'('h08);
  localparam logic [AW-1:0] A_DIN    = AW'('h0C);
  localparam logic [AW-1:0] A_STAT   = AW'('h10);
  localparam logic [AW-1:0] A_CLR    = AW'('h14);
  localparam logic [AW-1:0] A_MASK   = AW'('h18);
  localparam logic [AW-1:0] A_UNMASK = AW'('h1C);
  localparam logic [AW-1:0] A_POL    = AW'('h20);
  localparam logic [AW-1:0] A_EDGE   = AW'('h24);
  localparam logic [AW-1:0] A_FILT   = AW'('h28);
  localparam logic [AW-1:0] A_BOTH   = AW'('h4C);

  logic [NLINES-1:0] int_mode, dir_out, dout, pol_inv, edge_sel, both_sel, filt_en;
  logic [NLINES-1:0] irq_en, irq_st;
  logic [NLINES-1:0] sync1, sync2, sync3;
  logic [NLINES-1:0] wd, rise, fall, hit, clr, level, st_nxt;

  assign wd = bus_wdata[NLINES-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      int_mode <= '0; dir_out <= '0; dout <= '0; pol_inv <= '0;
      edge_sel <= '0; both_sel <= '0; filt_en <= '0; irq_en <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_MODE:   int_mode <= wd;
        A_DIR:    dir_out  <= wd;
        A_DOUT:   dout     <= wd;
        A_POL:    pol_inv  <= wd;
        A_EDGE:   edge_sel <= wd;
        A_BOTH:   both_sel <= wd;
        A_FILT:   filt_en  <= wd;
        A_MASK:   irq_en   <= irq_en & wd;
        A_UNMASK: irq_en   <= irq_en | wd;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= '0; sync2 <= '0; sync3 <= '0; irq_st <= '0;
    end else begin
      sync1  <= pin_in;
      sync2  <= sync1;
      sync3  <= sync2;
      irq_st <= st_nxt;
    end
  end

  assign rise   = sync2 & ~sync3;
  assign fall   = ~sync2 & sync3;
  assign hit    = (both_sel & (rise | fall)) | (~both_sel & ~pol_inv & rise)
                | (~both_sel & pol_inv & fall);
  assign clr    = (bus_we && bus_addr == A_CLR) ? wd : '0;
  assign level  = sync2 ^ pol_inv;
  assign st_nxt = int_mode & ((~edge_sel & level) | (edge_sel & (hit | (irq_st & ~clr))));

  assign pin_oe  = ~int_mode & dir_out;
  assign pin_out = dout & pin_oe;
  assign irq     = |(irq_st & irq_en);

  always_comb begin
    case (bus_addr)
      A_MODE:  bus_rdata = 32'(int_mode);
      A_DIR:   bus_rdata = 32'(dir_out);
      A_DOUT:  bus_rdata = 32'(dout);
      A_DIN:   bus_rdata = 32'(sync2);
      A_STAT:  bus_rdata = 32'(irq_st);
      A_MASK:  bus_rdata = 32'(irq_en);
      A_POL:   bus_rdata = 32'(pol_inv);
      A_EDGE:  bus_rdata = 32'(edge_sel);
      A_FILT:  bus_rdata = 32'(filt_en);
      A_BOTH:  bus_rdata = 32'(both_sel);
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int NLINES = 32,
  parameter int AW     = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic [AW-1:0]     bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              irq,
  input logic [NLINES-1:0] int_mode,
  input logic [NLINES-1:0] edge_sel,
  input logic [NLINES-1:0] irq_en,
  input logic [NLINES-1:0] irq_st
);
  localparam logic [AW-1:0] C_CLR    = AW'('h14);
  localparam logic [AW-1:0] C_MASK   = AW'('h18);
  localparam logic [AW-1:0] C_UNMASK = AW'('h1C);

  a_r9_disable_write: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == C_MASK) |=> ((irq_en & ~$past(bus_wdata[NLINES-1:0])) == '0));

  a_r9_enable_write: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == C_UNMASK) |=>
      ((irq_en & $past(bus_wdata[NLINES-1:0])) == $past(bus_wdata[NLINES-1:0])));

  a_r7_io_quiet: assert property (@(posedge clk) disable iff (rst)
    (int_mode == '0) |=> ((irq_st & ~$past(int_mode)) == '0));

  a_r10_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (irq_en == '0) |-> !irq);

  a_r8_sticky_hold: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_addr == C_CLR) |=>
      (($past(irq_st) & $past(int_mode) & $past(edge_sel) & ~irq_st) == '0));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NLINES(NLINES), .AW(AW)) chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .irq(irq), .int_mode(int_mode), .edge_sel(edge_sel), .irq_en(irq_en), .irq_st(irq_st)
);

// File: tb/gpio_irq_bank_test.sv
`timescale 1ns/1ps
module gpio_irq_bank_test;
  logic        clk = 0, rst = 1, bus_we = 0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, pin_in = '0, pin_out, pin_oe;
  logic        irq;
  int checks = 0, errors = 0;
  bit done = 0;

  gpio_irq_bank uut (.clk, .rst, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
                     .pin_in, .pin_out, .pin_oe, .irq);

  always #5 clk = ~clk;

  typedef struct packed {
    logic [31:0] mode, edg, pol, both, pre, post, exp;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0,        32'h0,        32'h0,        32'h0000FFFF, 32'h0000FFFF},
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0,        32'hFFFFFFFF, 32'hFFFF0000, 32'h0000FFFF},
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0,        32'h0,        32'hFFFFFFFF, 32'h0,        32'h0},
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'hF0F0F0F0, 32'hFFFFFFFF, 32'h00FF00FF, 32'h0F0F0F0F, 32'h0FF00FF0},
    '{32'hFFFFFFFF, 32'h0,        32'h0,        32'h0,        32'h0,        32'hA5A5A5A5, 32'hA5A5A5A5},
    '{32'hFFFFFFFF, 32'h0,        32'hFFFFFFFF, 32'h0,        32'h0,        32'h3C3C3C3C, 32'hC3C3C3C3},
    '{32'h0,        32'hFFFFFFFF, 32'h0,        32'h0,        32'h0,        32'hFFFFFFFF, 32'h0},
    '{32'hFFFFFFFF, 32'h0,        32'h0,        32'hFFFFFFFF, 32'h0,        32'h12345678, 32'h12345678},
    '{32'h0000FFFF, 32'hFFFFFFFF, 32'h0,        32'h0,        32'h0,        32'hFFFFFFFF, 32'h0000FFFF}
  };
  localparam string VTAG [9] = '{"R4 rise", "R4 fall", "R4 rise ignores fall", "R5 both",
    "R6 level high", "R6 level low", "R7 general mode", "R6 both ignored", "R7 mixed"};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk); bus_we = 0; bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    foreach (VECS[k]) begin end
    for (int a = 0; a < 128; a += 4) begin
      rd(7'(a), r);
      check($sformatf("R1 reset read %h", a), r, 0);
    end
    check("R1 reset oe", pin_oe, 0);
    check("R1 reset irq", 32'(irq), 0);

    // Vector table: R4 R5 R6 R7 with R10
    wr(7'h1C, 32'hFFFFFFFF);
    for (int i = 0; i < 9; i++) begin
      wr(7'h00, VECS[i].mode);
      wr(7'h24, VECS[i].edg);
      wr(7'h20, VECS[i].pol);
      wr(7'h4C, VECS[i].both);
      @(negedge clk); pin_in = VECS[i].pre;
      settle();
      wr(7'h14, 32'hFFFFFFFF);
      @(negedge clk); pin_in = VECS[i].post;
      settle();
      rd(7'h10, r);
      check(VTAG[i], r, VECS[i].exp);
      check({VTAG[i], " R10 irq"}, 32'(irq), 32'(VECS[i].exp != 0));
    end

    // R3 synchroniser latency
    wr(7'h00, 32'h0);
    @(negedge clk); pin_in = 32'h0; settle();
    @(negedge clk); bus_addr = 7'h0C; pin_in = 32'hDEADBEEF;
    @(posedge clk); #2 check("R3 din after one edge", bus_rdata, 32'h0);
    @(posedge clk); #2 check("R3 din after two edges", bus_rdata, 32'hDEADBEEF);

    // R9 enable mask
    wr(7'h18, 32'hFFFFFFF7);
    rd(7'h18, r); check("R9 mask zero disables", r, 32'hFFFFFFF7);
    wr(7'h1C, 32'h0);
    rd(7'h18, r); check("R9 unmask zero no effect", r, 32'hFFFFFFF7);
    wr(7'h18, 32'h0000FFFF);
    rd(7'h18, r); check("R9 mask ones unchanged", r, 32'h0000FFF7);

    // R10 gating by enable
    wr(7'h00, 32'hFFFFFFFF); wr(7'h24, 32'hFFFFFFFF); wr(7'h20, 0); wr(7'h4C, 0);
    @(negedge clk); pin_in = 0; settle();
    wr(7'h14, 32'hFFFFFFFF);
    @(negedge clk); pin_in = 32'h00100000; settle();
    check("R10 disabled line no irq", 32'(irq), 0);
    wr(7'h1C, 32'h00100000);
    check("R10 enabled line irq", 32'(irq), 1);

    // R8 clear
    @(negedge clk); pin_in = 32'h00100003; settle();
    rd(7'h10, r); check("R8 status before clear", r, 32'h00100003);
    wr(7'h14, 32'h00000001);
    rd(7'h10, r); check("R8 partial clear", r, 32'h00100002);
    wr(7'h14, 32'h0);
    rd(7'h10, r); check("R8 zero write no effect", r, 32'h00100002);
    @(negedge clk); pin_in = 32'h00100023;
    @(negedge clk);
    wr(7'h14, 32'h00000020);
    rd(7'h10, r); check("R8 set wins over clear", r, 32'h00100022);
    wr(7'h14, 32'h00000020);
    rd(7'h10, r); check("R8 clear after set", r, 32'h00100002);

    // R2 outputs
    wr(7'h00, 32'h0); wr(7'h04, 32'hFFFF0000); wr(7'h08, 32'h12345678);
    @(negedge clk);
    check("R2 oe", pin_oe, 32'hFFFF0000);
    check("R2 pin_out", pin_out, 32'h12340000);
    rd(7'h08, r); check("R2 dout readback", r, 32'h12345678);
    wr(7'h00, 32'h80000000);
    @(negedge clk);
    check("R2 interrupt mode drops oe", pin_oe, 32'h7FFF0000);
    check("R2 interrupt mode drops out", pin_out, 32'h12340000);

    // R11 storage and unmapped
    wr(7'h28, 32'hCAFEF00D);
    rd(7'h28, r); check("R11 filter storage", r, 32'hCAFEF00D);
    rd(7'h40, r); check("R11 unmapped", r, 0);
    rd(7'h1C, r); check("R11 unmask reads zero", r, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule